// File: doc/BRIEF.md
# Single-Entry Branch Hint Buffer

This block keeps one software-supplied branch hint and uses it to steer fetch. A hint-load port delivers a hint instruction: the hint's own address, a signed 11-bit trigger offset in instructions, a form code, an 18-bit immediate and a 32-bit register word. From these the block stores two word addresses. The first is the trigger, which is the address of the branch the hint predicts. The second is the target, taken from the register word, from the immediate alone, or from the hint address plus the immediate. Addresses are 18-bit byte addresses in a local store, and every offset counts 4-byte instructions, wrapping modulo 2^18.

Each instruction entering issue is compared with the stored trigger. On a match the block pulses a redirect to the stored target, provided the hint is old enough. A hint that is too young stalls the branch until enough cycles have passed. A hint that is far too young is dropped without a stall. The entry survives its own firing, so a hint placed before a loop predicts every iteration until a newer hint replaces it.

Top module: `branch_hint_buf`

## Requirements
- R1: A synchronous active-high reset empties the entry. After it, `hint_active` and `hint_ready` are 0 and no issue address produces a redirect or a stall until a new hint is accepted.
- R2: The trigger is the hint word address (`hint_pc[17:2]`) plus the sign-extended 11-bit `hint_off`, modulo 2^16 words. Issue addresses are matched on bits 17:2 only.
- R3: `redir_addr` has bits 1:0 equal to zero, and its upper bits depend on `hint_form`. Form 0 takes bits 17:2 of `hint_reg`. Form 1 takes the immediate times 4. Form 2 takes `hint_pc` plus the immediate times 4. All results are modulo 2^18.
- R4: When the entry is active and ready, `redir_valid` is 1 for exactly the cycles in which `iss_valid` is 1 and the issue address matches the trigger, and `redir_addr` carries the target.
- R5: Firing leaves the entry active. A later issue of the same trigger redirects again.
- R6: An accepted hint (form 0, 1 or 2) replaces the previous one and restarts its age counters. An issue in the same cycle as the load is judged against the previous entry.
- R7: A trigger match while the hint is ready-blocked raises `stall_req` and suppresses the redirect. Ready-blocked means at least 8 non-trigger instructions have issued but fewer than 11 `iss_tick` cycles have been counted since the load. The held branch keeps stalling until the 11th tick is counted and then redirects.
- R8: If the trigger is matched before 8 non-trigger instructions have issued, or before any `iss_tick` cycle has been counted, the hint is discarded. There is no stall and no redirect, and `hint_active` falls.
- R9: A hint whose signed offset lies outside -255..+255 is accepted as an inactive entry. It cancels the previous hint and never fires.
- R10: A load with form code 3 is ignored. The stored entry and its age counters are unchanged.
- R11: `hint_ready` is 1 exactly when the entry is active and both age thresholds (8 instructions, 11 ticks) have been reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hint_valid | input | 1 | Hint instruction present this cycle |
| hint_form | input | 2 | Target form: 0 register, 1 absolute, 2 relative, 3 ignored |
| hint_pc | input | 18 | Byte address of the hint instruction |
| hint_off | input | 11 | Signed trigger offset in instructions |
| hint_imm | input | 18 | Signed target immediate in instructions |
| hint_reg | input | 32 | Register word supplying the register-form target |
| iss_valid | input | 1 | An instruction is entering issue |
| iss_pc | input | 18 | Byte address of the issuing instruction |
| iss_tick | input | 1 | Counts one elapsed cycle toward the hint age |
| redir_valid | output | 1 | Speculative redirect strobe |
| redir_addr | output | 18 | Redirect target byte address |
| stall_req | output | 1 | Hold the issuing branch |
| hint_active | output | 1 | Entry holds a usable hint |
| hint_ready | output | 1 | Stored hint has reached both age thresholds |

## Verification
A table of hints is walked with each target form, with positive, negative and wrapping offsets and immediates, and with offsets at ±255 and ±256. This separates the three target computations and places the distance limit exactly. Each table hint is preceded by 5, 8, 9, 10, 11 or 12 filler instructions. The run therefore lands on the discard side, on each stall length from three cycles down to one, and on an immediate redirect, and the exact stall count shows off-by-one errors in either age counter. Directed sequences cover several further cases. Two hints in a row show that only the newest fires. A form-3 load shows it is ignored. A load and an issue in the same cycle show which entry is used. Withheld ticks show that stall and discard follow elapsed cycles as well as instruction count, and a reset in the middle of a run shows that the entry is cleared.

// File: rtl/hbb_pkg.sv
package hbb_pkg;

    localparam int ADDR_W   = 18;
    localparam int WORD_LSB = 2;
    localparam int WORD_W   = ADDR_W - WORD_LSB;
    localparam int OFF_W    = 11;
    localparam int IMM_W    = 18;
    localparam int REG_W    = 32;

    typedef enum logic [1:0] {
        FORM_REG = 2'd0,
        FORM_ABS = 2'd1,
        FORM_REL = 2'd2,
        FORM_RSV = 2'd3
    } hint_form_e;

    typedef logic [WORD_W-1:0] word_addr_t;

    typedef struct packed {
        logic       live;
        word_addr_t trig;
        word_addr_t tgt;
    } hint_entry_t;

    function automatic word_addr_t sext_off(input logic [OFF_W-1:0] off);
        return {{(WORD_W-OFF_W){off[OFF_W-1]}}, off};
    endfunction

endpackage

// File: rtl/hbb_addr_gen.sv
module hbb_addr_gen
    import hbb_pkg::*;
#(
    parameter int MAX_DIST = 255
) (
    input  hint_form_e         form,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [OFF_W-1:0]   off,
    input  logic [IMM_W-1:0]   imm,
    input  logic [REG_W-1:0]   regw,
    output word_addr_t         trig_w,
    output word_addr_t         tgt_w,
    output logic               in_range
);
    localparam logic signed [OFF_W-1:0] LIM_HI = OFF_W'(MAX_DIST);
    localparam logic signed [OFF_W-1:0] LIM_LO = -LIM_HI;

    word_addr_t               pc_w;
    word_addr_t               imm_w;
    logic signed [OFF_W-1:0]  off_s;
    logic                     unused_bits;

    assign pc_w        = pc[ADDR_W-1:WORD_LSB];
    assign imm_w       = imm[WORD_W-1:0];
    assign off_s       = off;
    assign unused_bits = ^{pc[WORD_LSB-1:0], imm[IMM_W-1:WORD_W],
                           regw[REG_W-1:ADDR_W], regw[WORD_LSB-1:0]};

    assign trig_w   = pc_w + sext_off(off);
    assign in_range = (off_s <= LIM_HI) && (off_s >= LIM_LO);

    always_comb begin
        unique case (form)
            FORM_REG: tgt_w = regw[ADDR_W-1:WORD_LSB];
            FORM_ABS: tgt_w = imm_w;
            FORM_REL: tgt_w = pc_w + imm_w;
            default:  tgt_w = '0;
        endcase
    end
endmodule

// File: rtl/hbb_window.sv
module hbb_window #(
    parameter int STALL_CYC  = 11,
    parameter int PAIR_INSTR = 8,
    parameter int EARLY_CYC  = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    input  logic count_instr,
    output logic too_early,
    output logic ready
);
    localparam int CW = $clog2(STALL_CYC + 1);
    localparam int IW = $clog2(PAIR_INSTR + 1);
    localparam logic [CW-1:0] C_MAX   = CW'(STALL_CYC);
    localparam logic [CW-1:0] C_EARLY = CW'(EARLY_CYC);
    localparam logic [IW-1:0] I_MAX   = IW'(PAIR_INSTR);

    logic [CW-1:0] cyc_q;
    logic [IW-1:0] ins_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cyc_q <= '0;
            ins_q <= '0;
        end else begin
            if (tick && cyc_q != C_MAX)
                cyc_q <= cyc_q + 1'b1;
            if (count_instr && ins_q != I_MAX)
                ins_q <= ins_q + 1'b1;
        end
    end

    assign too_early = (ins_q < I_MAX) || (cyc_q < C_EARLY);
    assign ready     = (cyc_q == C_MAX) && (ins_q == I_MAX);
endmodule

// File: rtl/hbb_entry.sv
module hbb_entry
    import hbb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic        load_live,
    input  word_addr_t  load_trig,
    input  word_addr_t  load_tgt,
    input  logic        drop,
    input  logic        iss_valid,
    input  word_addr_t  iss_w,
    output hint_entry_t ent,
    output logic        match
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else if (load) begin
            ent.live <= load_live;
            ent.trig <= load_trig;
            ent.tgt  <= load_tgt;
        end else if (drop) begin
            ent.live <= 1'b0;
        end
    end

    assign match = ent.live && iss_valid && (iss_w == ent.trig);
endmodule

// File: rtl/branch_hint_buf.sv
module branch_hint_buf
    import hbb_pkg::*;
#(
    parameter int MAX_DIST   = 255,
    parameter int STALL_CYC  = 11,
    parameter int PAIR_INSTR = 8,
    parameter int EARLY_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hint_valid,
    input  logic [1:0]        hint_form,
    input  logic [ADDR_W-1:0] hint_pc,
    input  logic [OFF_W-1:0]  hint_off,
    input  logic [IMM_W-1:0]  hint_imm,
    input  logic [REG_W-1:0]  hint_reg,
    input  logic              iss_valid,
    input  logic [ADDR_W-1:0] iss_pc,
    input  logic              iss_tick,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_addr,
    output logic              stall_req,
    output logic              hint_active,
    output logic              hint_ready
);
    hint_form_e  form;
    word_addr_t  new_trig, new_tgt;
    logic        new_in_range;
    logic        load_ok;
    hint_entry_t ent;
    logic        match, too_early, win_ready, drop;
    logic        unused_iss_lsb;

    assign form           = hint_form_e'(hint_form);
    assign load_ok        = hint_valid && (form != FORM_RSV);
    assign unused_iss_lsb = ^iss_pc[WORD_LSB-1:0];

    hbb_addr_gen #(.MAX_DIST(MAX_DIST)) u_gen (
        .form     (form),
        .pc       (hint_pc),
        .off      (hint_off),
        .imm      (hint_imm),
        .regw     (hint_reg),
        .trig_w   (new_trig),
        .tgt_w    (new_tgt),
        .in_range (new_in_range)
    );

    hbb_entry u_entry (
        .clk       (clk),
        .rst       (rst),
        .load      (load_ok),
        .load_live (new_in_range),
        .load_trig (new_trig),
        .load_tgt  (new_tgt),
        .drop      (drop),
        .iss_valid (iss_valid),
        .iss_w     (iss_pc[ADDR_W-1:WORD_LSB]),
        .ent       (ent),
        .match     (match)
    );

    hbb_window #(
        .STALL_CYC (STALL_CYC),
        .PAIR_INSTR(PAIR_INSTR),
        .EARLY_CYC (EARLY_CYC)
    ) u_win (
        .clk         (clk),
        .rst         (rst),
        .restart     (load_ok),
        .tick        (iss_tick),
        .count_instr (iss_valid && !match),
        .too_early   (too_early),
        .ready       (win_ready)
    );

    assign drop        = match && too_early;
    assign redir_valid = match && win_ready;
    assign stall_req   = match && !win_ready && !too_early;
    assign redir_addr  = {ent.tgt, {WORD_LSB{1'b0}}};
    assign hint_active = ent.live;
    assign hint_ready  = ent.live && win_ready;
endmodule

// File: rtl/branch_hint_buf_chk.sv
module branch_hint_buf_chk (
    input logic       clk,
    input logic       rst,
    input logic       hint_valid,
    input logic [1:0] hint_form,
    input logic       iss_valid,
    input logic       redir_valid,
    input logic       stall_req,
    input logic       hint_active,
    input logic       hint_ready
);
    logic rst_q;

    always_ff @(posedge clk) begin
        if (rst_q)
            assert_reset_clear_R1: assert (!hint_active && !hint_ready)
                else $error("entry not empty after reset");
        rst_q <= rst;
    end

    assert_redir_gate_R4: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (iss_valid && hint_active && hint_ready));

    assert_keep_after_fire_R5: assert property (@(posedge clk) disable iff (rst)
        (redir_valid && !hint_valid) |=> hint_active);

    assert_restart_age_R6: assert property (@(posedge clk) disable iff (rst)
        (hint_valid && hint_form != 2'd3) |=> !hint_ready);

    assert_stall_excl_R7: assert property (@(posedge clk) disable iff (rst)
        stall_req |-> (iss_valid && hint_active && !hint_ready && !redir_valid));

    assert_rsv_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (hint_valid && hint_form == 2'd3 && !iss_valid) |=> $stable(hint_active));
endmodule

bind branch_hint_buf branch_hint_buf_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .hint_valid  (hint_valid),
    .hint_form   (hint_form),
    .iss_valid   (iss_valid),
    .redir_valid (redir_valid),
    .stall_req   (stall_req),
    .hint_active (hint_active),
    .hint_ready  (hint_ready)
);

// File: tb/branch_hint_buf_tb.sv
module branch_hint_buf_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        hint_valid;
    logic [1:0]  hint_form;
    logic [17:0] hint_pc;
    logic [10:0] hint_off;
    logic [17:0] hint_imm;
    logic [31:0] hint_reg;
    logic        iss_valid;
    logic [17:0] iss_pc;
    logic        iss_tick;
    logic        redir_valid;
    logic [17:0] redir_addr;
    logic        stall_req;
    logic        hint_active;
    logic        hint_ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic        s_redir, s_stall, s_active, s_ready;
    logic [17:0] s_addr;

    always #5 clk = ~clk;

    branch_hint_buf u_dut (
        .clk(clk), .rst(rst),
        .hint_valid(hint_valid), .hint_form(hint_form), .hint_pc(hint_pc),
        .hint_off(hint_off), .hint_imm(hint_imm), .hint_reg(hint_reg),
        .iss_valid(iss_valid), .iss_pc(iss_pc), .iss_tick(iss_tick),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .stall_req(stall_req), .hint_active(hint_active), .hint_ready(hint_ready)
    );

    typedef struct packed {
        logic [1:0]  form;
        logic [17:0] pc;
        logic [10:0] off;
        logic [17:0] imm;
        logic [31:0] regw;
        int          n;
        int          exp;   // >=0 stall cycles before redirect, -1 discarded, -2 never fires
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 18'h01000, 11'd20,   18'h00000, 32'h12345677, 12,  0},
        '{2'd1, 18'h02000, 11'd40,   18'h20010, 32'h0,        11,  0},
        '{2'd2, 18'h3FFF0, 11'h7FC,  18'h00008, 32'h0,         9,  2},
        '{2'd2, 18'h00400, 11'd8,    18'h3FFFF, 32'h0,         8,  3},
        '{2'd1, 18'h00800, 11'd16,   18'h00100, 32'h0,         5, -1},
        '{2'd0, 18'h01000, 11'd256,  18'h00000, 32'h00001230, 12, -2},
        '{2'd2, 18'h10000, 11'h701,  18'h00010, 32'h0,        11,  0},
        '{2'd1, 18'h10000, 11'd255,  18'h01234, 32'h0,        10,  1},
        '{2'd2, 18'h10000, 11'h700,  18'h00020, 32'h0,        12, -2}
    };

    function automatic int exp_trig(logic [17:0] pc, logic [10:0] off);
        int o = int'(off);
        if (o >= 1024) o = o - 2048;
        return (int'(pc) + 4 * o) & 32'h3FFFF;
    endfunction

    function automatic int exp_tgt(logic [1:0] f, logic [17:0] pc, logic [17:0] imm,
                                   logic [31:0] regw);
        case (f)
            2'd0:    return int'(regw) & 32'h3FFFC;
            2'd1:    return (int'(imm) * 4) & 32'h3FFFF;
            default: return (int'(pc) + int'(imm) * 4) & 32'h3FFFF;
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic sample();
        #4;
        s_redir  = redir_valid;
        s_stall  = stall_req;
        s_addr   = redir_addr;
        s_active = hint_active;
        s_ready  = hint_ready;
    endtask

    task automatic load(logic [1:0] f, logic [17:0] pc, logic [10:0] off,
                        logic [17:0] imm, logic [31:0] regw, logic with_iss,
                        int iaddr);
        @(posedge clk); #1;
        hint_valid = 1'b1; hint_form = f; hint_pc = pc; hint_off = off;
        hint_imm = imm; hint_reg = regw;
        iss_valid = with_iss; iss_pc = iaddr[17:0]; iss_tick = 1'b1;
        sample();
    endtask

    task automatic issue(int addr, logic tk);
        @(posedge clk); #1;
        hint_valid = 1'b0; iss_valid = 1'b1; iss_pc = addr[17:0]; iss_tick = tk;
        sample();
    endtask

    task automatic fill(int trig, int n, logic tk);
        for (int i = 0; i < n; i++) issue((trig + 4 * (i + 1)) & 32'h3FFFF, tk);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; hint_valid = 1'b0; iss_valid = 1'b0; iss_tick = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int ta, ga, tb, gb;
        rst = 1'b1; hint_valid = 1'b0; hint_form = 2'd0; hint_pc = '0;
        hint_off = '0; hint_imm = '0; hint_reg = '0;
        iss_valid = 1'b0; iss_pc = '0; iss_tick = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        issue(32'h01050, 1'b1);
        chk("R1", "active after reset", s_active, 0);
        chk("R1", "ready after reset", s_ready, 0);
        chk("R1", "redirect after reset", s_redir, 0);
        chk("R1", "stall after reset", s_stall, 0);

        // Vector table: R2 R3 R4 R5 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            vec_t c;
            int trig, tgt, stalls;
            bit got;
            c = VEC[v];
            trig = exp_trig(c.pc, c.off);
            tgt  = exp_tgt(c.form, c.pc, c.imm, c.regw);
            load(c.form, c.pc, c.off, c.imm, c.regw, 1'b0, 0);
            fill(trig, 1, 1'b1);
            chk("R9", "active after load", s_active, (c.exp == -2) ? 0 : 1);
            fill(trig + 4, c.n - 1, 1'b1);
            stalls = 0; got = 1'b0;
            for (int k = 0; k < 20; k++) begin
                issue(trig, 1'b1);
                if (s_redir) begin got = 1'b1; break; end
                else if (s_stall) stalls++;
                else break;
            end
            if (c.exp >= 0) begin
                chk("R4", "redirect seen", got, 1);
                chk("R7", "stall cycles", stalls, c.exp);
                chk("R3", "target address", s_addr, tgt);
                issue(trig, 1'b1);
                chk("R5", "second redirect", s_redir, 1);
                chk("R11", "ready flag", s_ready, 1);
            end else if (c.exp == -1) begin
                chk("R8", "no redirect when early", got, 0);
                chk("R8", "no stall when early", stalls, 0);
                fill(trig, 12, 1'b1);
                issue(trig, 1'b1);
                chk("R8", "entry dropped", s_active, 0);
                chk("R8", "no later redirect", s_redir, 0);
            end else begin
                chk("R9", "far hint no redirect", got, 0);
                chk("R9", "far hint no stall", stalls, 0);
            end
        end

        ta = exp_trig(18'h01000, 11'd20); ga = exp_tgt(2'd0, 18'h01000, 18'h0, 32'h000ABC0);
        tb = exp_trig(18'h05000, 11'd20); gb = exp_tgt(2'd1, 18'h05000, 18'h00400, 32'h0);

        // R6: newer hint cancels older
        load(2'd0, 18'h01000, 11'd20, 18'h0, 32'h000ABC0, 1'b0, 0);
        load(2'd1, 18'h05000, 11'd20, 18'h00400, 32'h0, 1'b0, 0);
        fill(tb, 12, 1'b1);
        issue(ta, 1'b1);
        chk("R6", "old trigger silent", s_redir | s_stall, 0);
        issue(tb, 1'b1);
        chk("R6", "new trigger fires", s_redir, 1);
        chk("R6", "new target", s_addr, gb);

        // R9: out-of-range hint still cancels the previous one
        load(2'd2, 18'h05000, 11'd300, 18'h0, 32'h0, 1'b0, 0);
        fill(tb, 12, 1'b1);
        issue(tb, 1'b1);
        chk("R9", "cancelled by far hint", s_redir, 0);
        chk("R9", "inactive after far hint", s_active, 0);

        // R10: form code 3 is ignored
        load(2'd0, 18'h01000, 11'd20, 18'h0, 32'h000ABC0, 1'b0, 0);
        fill(ta, 12, 1'b1);
        load(2'd3, 18'h05000, 11'd20, 18'h00400, 32'h0, 1'b0, 0);
        issue(ta, 1'b1);
        chk("R10", "old hint still fires", s_redir, 1);
        chk("R10", "old target kept", s_addr, ga);

        // R6: issue in load cycle uses previous entry
        load(2'd1, 18'h05000, 11'd20, 18'h00400, 32'h0, 1'b1, ta);
        chk("R6", "load-cycle redirect from old", s_redir, 1);
        chk("R6", "load-cycle old target", s_addr, ga);
        issue(ta, 1'b1);
        chk("R6", "old gone after load", s_redir | s_stall, 0);

        // R7: stall follows ticks, not just cycles
        load(2'd0, 18'h01000, 11'd20, 18'h0, 32'h000ABC0, 1'b0, 0);
        fill(ta, 8, 1'b1);
        for (int k = 0; k < 4; k++) begin
            issue(ta, 1'b0);
            chk("R7", "stall without tick", s_stall, 1);
        end
        for (int k = 0; k < 3; k++) begin
            issue(ta, 1'b1);
            chk("R7", "stall while aging", s_stall, 1);
        end
        issue(ta, 1'b1);
        chk("R7", "redirect after aging", s_redir, 1);

        // R8: enough instructions but no tick counted -> discard
        load(2'd0, 18'h01000, 11'd20, 18'h0, 32'h000ABC0, 1'b0, 0);
        fill(ta, 8, 1'b0);
        issue(ta, 1'b0);
        chk("R8", "zero-tick no stall", s_stall | s_redir, 0);
        issue(ta, 1'b1);
        chk("R8", "zero-tick dropped", s_active, 0);

        // R1: reset in mid-run clears a ready hint
        load(2'd0, 18'h01000, 11'd20, 18'h0, 32'h000ABC0, 1'b0, 0);
        fill(ta, 12, 1'b1);
        do_reset();
        issue(ta, 1'b1);
        chk("R1", "no redirect after reset", s_redir, 0);
        chk("R1", "inactive after reset", s_active, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule